// File: doc/BRIEF.md
# Strided Interleaved Vector Memory Access Unit

This unit moves one vector between a vector register port and a word-addressed memory that is split into interleaved banks. A command gives a base word address, a stride, an element count and a direction (load or store). The unit walks the elements in order and forms each address as base plus index times stride. Each address goes to the bank named by its low address bits. A bank that was just accessed must rest for a fixed number of cycles. While the bank of the next element is resting, issue holds that element. Elements are never issued out of order.

A store takes its write data from a stream that the unit indexes by element number. A load returns each word a fixed number of cycles after its request, tagged with its element index, on a write port meant for a vector register. A one-cycle done pulse closes each command. The banked storage is a plain behavioural array written so that each bank can map onto a block RAM.

How fast a command runs depends on how its stride relates to the bank count. A stride with no common factor with 16 spreads over all banks and issues one element per cycle. A stride such as 8 or 16 keeps hitting the same few banks and stalls.

Top module: `vec_stride_mem`

## Requirements
- R1: During and straight after reset, cmd_ready is 1 and ld_valid and done are 0.
- R2: Element i uses word address (base + i*stride) modulo 2^ADDR_W. A stride of 2^ADDR_W-1 therefore walks downward, and addresses wrap past the top of memory.
- R3: The bank of a word address is its low 4 bits (16 banks). A bank accessed in cycle t accepts no other access before cycle t+4, and this holds across command boundaries.
- R4: At most one element issues per cycle, and always in element order. Element 0 issues in the cycle after the command is accepted if its bank is free. Any later element issues one cycle after the one before it unless R3 holds it back.
- R5: A load element issued in cycle t appears with ld_valid=1, ld_idx=i and the stored word on ld_data in cycle t+12.
- R6: A store element issues in the cycle where st_take=1. In that cycle it writes st_data to memory as the word for element st_idx. done pulses in the cycle after the last store issue.
- R7: For a load, done pulses in the cycle after the last element returns, and never together with ld_valid.
- R8: A command of length 0 pulses done in the cycle after acceptance. It makes no access and leaves memory unchanged.
- R9: A command is accepted only while cmd_ready=1. A cmd_valid raised while a command is in progress is ignored: nothing issues, memory is unchanged and no extra done appears.
- R10: The largest vector length is 64. A requested length above 64 moves exactly 64 elements.
- R11: A stride coprime with 16 issues one element per cycle with no stall. A stride of 16 issues one element every 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle; a command is taken in this cycle when cmd_valid is 1 |
| cmd_base | input | ADDR_W (10) | Word address of element 0 |
| cmd_stride | input | ADDR_W (10) | Word step between elements, modulo 2^ADDR_W |
| cmd_len | input | LEN_W (7) | Requested element count |
| cmd_store | input | 1 | 1 = store, 0 = load |
| st_take | output | 1 | Store element issuing this cycle |
| st_idx | output | IDX_W (6) | Element index whose store data is needed |
| st_data | input | DATA_W (32) | Store data for element st_idx |
| ld_valid | output | 1 | Load element returned |
| ld_idx | output | IDX_W (6) | Element index of returned data |
| ld_data | output | DATA_W (32) | Returned word |
| done | output | 1 | One-cycle pulse at command completion |

## Verification
Two things can land in the same cycle. The first is the issue of a later load element and the return of an earlier one. Every load longer than 12 elements provokes this, and the full 64-element load keeps the two active together for over 50 cycles. It is judged by requiring every return in exact element order, in the exact cycle the bench's own bank schedule predicts, with the data its memory model holds. The second is a new command's first issue and the end of a bank's rest period from the previous command. A store of stride 16 followed at once by a load to the same bank provokes this, and the load's return cycles show whether issue waited exactly until the bank was free again.

// File: rtl/vsm_pkg.sv
package vsm_pkg;

  // Sequencer states of the vector memory access unit
  typedef enum logic [1:0] {
    VSM_IDLE  = 2'd0,
    VSM_ISSUE = 2'd1,
    VSM_DRAIN = 2'd2
  } vsm_state_e;

endpackage

// File: rtl/vsm_agen.sv
// Element address generator: holds the running word address and element index.
module vsm_agen #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [IDX_W-1:0]  last_in,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [IDX_W-1:0]  last_idx,
  output logic              last
);

  logic [ADDR_W-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr     <= '0;
      idx      <= '0;
      last_idx <= '0;
      step_q   <= '0;
    end else if (start) begin
      addr     <= base;
      idx      <= '0;
      last_idx <= last_in;
      step_q   <= stride;
    end else if (adv) begin
      addr <= addr + step_q;
      idx  <= idx + 1'b1;
    end
  end

  assign last = (idx == last_idx);

endmodule

// File: rtl/vsm_bank_timers.sv
// One rest counter per bank; a bank is free when its counter is zero.
module vsm_bank_timers #(
  parameter int NUM_BANKS = 16,
  parameter int BUSY_CYC  = 4,
  localparam int BANK_BITS = $clog2(NUM_BANKS),
  localparam int CNT_W     = $clog2(BUSY_CYC + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hit,
  input  logic [BANK_BITS-1:0] hit_bank,
  output logic [NUM_BANKS-1:0] free
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt <= '0;
      end else if (hit && (hit_bank == BANK_BITS'(g))) begin
        cnt <= CNT_W'(BUSY_CYC - 1);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end

    assign free[g] = (cnt == '0);
  end

endmodule

// File: rtl/vsm_bank_mem.sv
// Interleaved banks, each a single-port array with a registered read.
module vsm_bank_mem #(
  parameter int NUM_BANKS = 16,
  parameter int ROW_W     = 6,
  parameter int DATA_W    = 32,
  localparam int BANK_BITS = $clog2(NUM_BANKS),
  localparam int ROWS      = 1 << ROW_W
) (
  input  logic                 clk,
  input  logic                 en,
  input  logic                 we,
  input  logic [BANK_BITS-1:0] bank,
  input  logic [ROW_W-1:0]     row,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata
);

  logic [DATA_W-1:0]    bank_rd [NUM_BANKS];
  logic [BANK_BITS-1:0] sel_q;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [DATA_W-1:0] mem [ROWS];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (en && (bank == BANK_BITS'(g))) begin
        if (we) mem[row] <= wdata;
        else    rd_q     <= mem[row];
      end
    end

    assign bank_rd[g] = rd_q;
  end

  always_ff @(posedge clk) begin
    if (en) sel_q <= bank;
  end

  assign rdata = bank_rd[sel_q];

endmodule

// File: rtl/vsm_ret_pipe.sv
// Fixed-latency load return: stage 0 runs alongside the bank read,
// later stages carry data, so an input in cycle t leaves in cycle t+LAT.
module vsm_ret_pipe #(
  parameter int LAT    = 12,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [DATA_W-1:0] rdata,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_idx,
  output logic [DATA_W-1:0] out_data
);

  logic [LAT-1:0]    vld_q;
  logic [IDX_W-1:0]  idx_q [LAT];
  logic [DATA_W-1:0] dat_q [1:LAT-1];

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    idx_q[0] <= in_idx;
    dat_q[1] <= rdata;
    for (int k = 1; k < LAT; k++) idx_q[k] <= idx_q[k-1];
    for (int k = 2; k < LAT; k++) dat_q[k] <= dat_q[k-1];
  end

  assign out_valid = vld_q[LAT-1];
  assign out_idx   = idx_q[LAT-1];
  assign out_data  = dat_q[LAT-1];

endmodule

// File: rtl/vec_stride_mem.sv
// Strided vector load/store unit over interleaved banks with rest timers.
module vec_stride_mem
  import vsm_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 16,
  parameter int BUSY_CYC  = 4,
  parameter int LOAD_LAT  = 12,
  parameter int MAX_VL    = 64,
  localparam int BANK_BITS = $clog2(NUM_BANKS),
  localparam int ROW_W     = ADDR_W - BANK_BITS,
  localparam int IDX_W     = $clog2(MAX_VL),
  localparam int LEN_W     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [ADDR_W-1:0] cmd_stride,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_store,
  output logic              st_take,
  output logic [IDX_W-1:0]  st_idx,
  input  logic [DATA_W-1:0] st_data,
  output logic              ld_valid,
  output logic [IDX_W-1:0]  ld_idx,
  output logic [DATA_W-1:0] ld_data,
  output logic              done
);

  vsm_state_e state_q;
  logic       store_q;
  logic       done_q;

  logic              accept;
  logic [LEN_W-1:0]  len_eff;
  logic [IDX_W-1:0]  last_in;
  logic [ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  cur_idx;
  logic [IDX_W-1:0]  last_idx;
  logic              last_elem;
  logic [BANK_BITS-1:0] cur_bank;
  logic [ROW_W-1:0]  cur_row;
  logic [NUM_BANKS-1:0] bank_free;
  logic              iss;
  logic [DATA_W-1:0] mem_rdata;

  assign cmd_ready = (state_q == VSM_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign len_eff   = (cmd_len > LEN_W'(MAX_VL)) ? LEN_W'(MAX_VL) : cmd_len;
  assign last_in   = IDX_W'(len_eff - LEN_W'(1));

  assign cur_bank  = cur_addr[BANK_BITS-1:0];
  assign cur_row   = cur_addr[ADDR_W-1:BANK_BITS];
  assign iss       = (state_q == VSM_ISSUE) && bank_free[cur_bank];

  assign st_take   = iss && store_q;
  assign st_idx    = cur_idx;
  assign done      = done_q;

  vsm_agen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_agen (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .base     (cmd_base),
    .stride   (cmd_stride),
    .last_in  (last_in),
    .adv      (iss),
    .addr     (cur_addr),
    .idx      (cur_idx),
    .last_idx (last_idx),
    .last     (last_elem)
  );

  vsm_bank_timers #(.NUM_BANKS(NUM_BANKS), .BUSY_CYC(BUSY_CYC)) u_timers (
    .clk      (clk),
    .rst      (rst),
    .hit      (iss),
    .hit_bank (cur_bank),
    .free     (bank_free)
  );

  vsm_bank_mem #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .en    (iss),
    .we    (store_q),
    .bank  (cur_bank),
    .row   (cur_row),
    .wdata (st_data),
    .rdata (mem_rdata)
  );

  vsm_ret_pipe #(.LAT(LOAD_LAT), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ret (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (iss && !store_q),
    .in_idx    (cur_idx),
    .rdata     (mem_rdata),
    .out_valid (ld_valid),
    .out_idx   (ld_idx),
    .out_data  (ld_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= VSM_IDLE;
      store_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        VSM_IDLE: begin
          if (accept) begin
            store_q <= cmd_store;
            if (len_eff == '0) done_q  <= 1'b1;
            else               state_q <= VSM_ISSUE;
          end
        end
        VSM_ISSUE: begin
          if (iss && last_elem) begin
            if (store_q) begin
              done_q  <= 1'b1;
              state_q <= VSM_IDLE;
            end else begin
              state_q <= VSM_DRAIN;
            end
          end
        end
        VSM_DRAIN: begin
          if (ld_valid && (ld_idx == last_idx)) begin
            done_q  <= 1'b1;
            state_q <= VSM_IDLE;
          end
        end
        default: state_q <= VSM_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vsm_checker.sv
module vsm_checker #(
  parameter int NUM_BANKS = 16,
  parameter int BUSY_CYC  = 4,
  parameter int IDX_W     = 6,
  parameter int LEN_W     = 7,
  localparam int BANK_BITS = $clog2(NUM_BANKS),
  localparam int GAP_W     = $clog2(BUSY_CYC + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic [LEN_W-1:0]     cmd_len,
  input logic                 iss,
  input logic [BANK_BITS-1:0] iss_bank,
  input logic                 st_take,
  input logic [IDX_W-1:0]     st_idx,
  input logic                 ld_valid,
  input logic [IDX_W-1:0]     ld_idx,
  input logic                 done
);

  logic [GAP_W-1:0] gap [NUM_BANKS];
  logic [IDX_W-1:0] st_prev;
  logic [IDX_W-1:0] ld_prev;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_gap
    always_ff @(posedge clk) begin
      if (rst) gap[g] <= GAP_W'(BUSY_CYC);
      else if (iss && (iss_bank == BANK_BITS'(g))) gap[g] <= GAP_W'(1);
      else if (gap[g] < GAP_W'(BUSY_CYC)) gap[g] <= gap[g] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_prev <= '0;
      ld_prev <= '0;
    end else begin
      if (st_take)  st_prev <= st_idx;
      if (ld_valid) ld_prev <= ld_idx;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (cmd_ready && !ld_valid && !done)); // R1

  AST_BANK_REST: assert property (@(posedge clk) disable iff (rst)
    iss |-> (gap[iss_bank] >= GAP_W'(BUSY_CYC))); // R3

  AST_STORE_ORDER: assert property (@(posedge clk) disable iff (rst)
    (st_take && (st_idx != '0)) |-> (st_idx == IDX_W'(st_prev + 1'b1))); // R4

  AST_LOAD_ORDER: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && (ld_idx != '0)) |-> (ld_idx == IDX_W'(ld_prev + 1'b1))); // R5

  AST_DONE_APART: assert property (@(posedge clk) disable iff (rst)
    done |-> !ld_valid); // R7

  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && (cmd_len == '0)) |=> (done && !iss)); // R8

  AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !iss); // R9

endmodule

bind vec_stride_mem vsm_checker #(
  .NUM_BANKS (NUM_BANKS),
  .BUSY_CYC  (BUSY_CYC),
  .IDX_W     (IDX_W),
  .LEN_W     (LEN_W)
) u_vsm_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_len   (cmd_len),
  .iss       (iss),
  .iss_bank  (cur_bank),
  .st_take   (st_take),
  .st_idx    (st_idx),
  .ld_valid  (ld_valid),
  .ld_idx    (ld_idx),
  .done      (done)
);

// File: tb/vec_stride_mem_test.sv
`timescale 1ns/1ps
module vec_stride_mem_test;

  localparam int AW = 10, DW = 32, BUSY = 4, LAT = 12, MAXVL = 64;
  localparam int IW = 6, LW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_base = '0;
  logic [AW-1:0] cmd_stride = '0;
  logic [LW-1:0] cmd_len = '0;
  logic          cmd_store = 1'b0;
  logic          st_take;
  logic [IW-1:0] st_idx;
  logic [DW-1:0] st_data;
  logic          ld_valid;
  logic [IW-1:0] ld_idx;
  logic [DW-1:0] ld_data;
  logic          done;
  logic [15:0]   cur_tag = '0;

  always #2.5 clk = ~clk;

  assign st_data = {cur_tag, 10'd0, st_idx};

  vec_stride_mem uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_len(cmd_len),
    .cmd_store(cmd_store), .st_take(st_take), .st_idx(st_idx),
    .st_data(st_data), .ld_valid(ld_valid), .ld_idx(ld_idx),
    .ld_data(ld_data), .done(done)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] mdl [1024];
  int bank_last [16];
  int n_chk = 0;
  int n_fail = 0;
  int last_n = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Runs one command; treq names the requirement judged by the timing check.
  task automatic run_cmd(input int base, input int stride, input int len,
                         input bit store, input logic [15:0] tag,
                         input string treq, input bit intrude);
    int acc, eff, prev, t, b, n_ev, done_c, k, exp_d, bad_a, bad_e;
    int t_exp [64];
    int addr_of [64];
    int ev_cyc [64];
    int ev_idx [64];
    logic [31:0] ev_dat [64];
    bit ok_t, ok_d;
    while (!cmd_ready) @(negedge clk);
    cur_tag    = tag;
    cmd_valid  = 1'b1;
    cmd_base   = AW'(base);
    cmd_stride = AW'(stride);
    cmd_len    = LW'(len);
    cmd_store  = store;
    acc = cyc;
    eff = (len > MAXVL) ? MAXVL : len;
    prev = acc;
    for (int i = 0; i < eff; i++) begin
      addr_of[i] = (base + i * stride) & 1023;
      b = addr_of[i] & 15;
      t = prev + 1;
      if (bank_last[b] + BUSY > t) t = bank_last[b] + BUSY;
      t_exp[i] = t;
      bank_last[b] = t;
      prev = t;
    end
    n_ev = 0; done_c = -1; k = 0;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (done_c < 0 && k < 600) begin
      if (intrude && k == 3) begin
        cmd_valid = 1'b1; cmd_base = '0; cmd_stride = AW'(1);
        cmd_len = LW'(16); cmd_store = 1'b1; cur_tag = 16'hDEAD;
      end else if (intrude && k == 4) begin
        cmd_valid = 1'b0; cur_tag = tag;
      end
      if (store ? st_take : ld_valid) begin
        if (n_ev < 64) begin
          ev_cyc[n_ev] = cyc;
          ev_idx[n_ev] = store ? int'(st_idx) : int'(ld_idx);
          ev_dat[n_ev] = ld_data;
        end
        n_ev++;
      end
      if ((store && ld_valid) || (!store && st_take)) n_ev += 100;
      if (done) done_c = cyc;
      k++;
      if (done_c < 0) @(negedge clk);
    end
    last_n = n_ev;
    check(n_ev == eff, (eff == 0) ? "R8" : (store ? "R6" : "R5"),
          "element count", n_ev, eff);
    ok_t = 1'b1; bad_a = 0; bad_e = 0;
    for (int i = 0; i < eff && i < n_ev && i < 64; i++) begin
      t = store ? t_exp[i] : t_exp[i] + LAT;
      if (ok_t && (ev_cyc[i] != t || ev_idx[i] != i)) begin
        ok_t = 1'b0; bad_a = ev_cyc[i] - acc; bad_e = t - acc;
      end
    end
    if (eff > 0) check(ok_t, treq, "element cycle after accept", bad_a, bad_e);
    if (eff == 0)   exp_d = acc + 1;
    else if (store) exp_d = t_exp[eff-1] + 1;
    else            exp_d = t_exp[eff-1] + LAT + 1;
    check(done_c == exp_d, (eff == 0) ? "R8" : (store ? "R6" : "R7"),
          "done cycle after accept", done_c - acc, exp_d - acc);
    if (store) begin
      for (int i = 0; i < eff; i++) mdl[addr_of[i]] = {tag, 10'd0, 6'(i)};
    end else if (eff > 0) begin
      ok_d = 1'b1; bad_a = 0; bad_e = 0;
      for (int i = 0; i < eff && i < n_ev && i < 64; i++) begin
        if (ok_d && ev_dat[i] !== mdl[addr_of[i]]) begin
          ok_d = 1'b0; bad_a = int'(ev_dat[i]); bad_e = int'(mdl[addr_of[i]]);
        end
      end
      check(ok_d, "R2", "load data", bad_a, bad_e);
    end
    if (intrude) begin
      @(negedge clk); check(!done, "R9", "extra done", done, 0);
      @(negedge clk); check(!done, "R9", "extra done", done, 0);
    end
  endtask

  task automatic t_reset();
    check(cmd_ready == 1'b1, "R1", "cmd_ready after reset", cmd_ready, 1);
    check(!ld_valid && !done, "R1", "ld_valid/done after reset", {ld_valid, done}, 0);
  endtask

  task automatic t_unit_stride();
    run_cmd(0, 1, 16, 1'b1, 16'h0001, "R11", 1'b0);
    run_cmd(0, 1, 16, 1'b0, 16'h0000, "R4", 1'b0);
  endtask

  task automatic t_stride8();
    run_cmd(100, 8, 8, 1'b1, 16'h0002, "R3", 1'b0);
    run_cmd(100, 8, 8, 1'b0, 16'h0000, "R3", 1'b0);
  endtask

  task automatic t_stride16();
    run_cmd(3, 16, 6, 1'b1, 16'h0003, "R11", 1'b0);
    run_cmd(3, 16, 6, 1'b0, 16'h0000, "R11", 1'b0);
  endtask

  task automatic t_coprime();
    run_cmd(200, 3, 20, 1'b1, 16'h0004, "R11", 1'b0);
    run_cmd(200, 3, 20, 1'b0, 16'h0000, "R5", 1'b0);
  endtask

  task automatic t_full_and_clamp();
    run_cmd(512, 1, 64, 1'b1, 16'h0005, "R10", 1'b0);
    run_cmd(512, 1, 64, 1'b0, 16'h0000, "R10", 1'b0);
    run_cmd(512, 1, 100, 1'b1, 16'h0006, "R10", 1'b0);
    check(last_n == 64, "R10", "elements moved for length 100", last_n, 64);
    run_cmd(512, 1, 64, 1'b0, 16'h0000, "R5", 1'b0);
  endtask

  task automatic t_zero_len();
    run_cmd(0, 1, 0, 1'b1, 16'h0007, "R8", 1'b0);
    run_cmd(0, 1, 16, 1'b0, 16'h0000, "R8", 1'b0);
  endtask

  task automatic t_busy_ignore();
    run_cmd(512, 1, 64, 1'b0, 16'h0000, "R9", 1'b1);
    run_cmd(0, 1, 16, 1'b0, 16'h0000, "R9", 1'b0);
  endtask

  task automatic t_wrap();
    run_cmd(1020, 1, 8, 1'b1, 16'h0008, "R2", 1'b0);
    run_cmd(3, 1023, 8, 1'b0, 16'h0000, "R2", 1'b0);
  endtask

  task automatic t_cross_cmd_bank();
    run_cmd(7, 16, 2, 1'b1, 16'h0009, "R3", 1'b0);
    run_cmd(7, 16, 2, 1'b0, 16'h0000, "R3", 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) bank_last[i] = -100;
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unit_stride();
    t_stride8();
    t_stride16();
    t_coprime();
    t_full_and_clamp();
    t_zero_len();
    t_busy_ignore();
    t_wrap();
    t_cross_cmd_bank();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule